// File: doc/BRIEF.md
# Indexed Interrupt Enable Controller

This block distributes level-sensitive interrupt sources to a small group of CPUs. Each CPU has one IRQ output and one FIQ output. Software reaches the block through one register window that all CPUs share and one private window for each CPU. Each source has a routing word that picks the CPUs it may reach and the line it uses on each of them.

Software does not change enables and masks by editing bit masks. It writes a source number to a set register or to a clear register. The low-numbered private sources (below 32) have a separate mask copy for each CPU. A CPU changes only its own copy, through its own window. The higher shared sources have one global enable. A master enable in the control register gates every output.

Each CPU window has two read registers. The cause register shows the pending private sources routed to that CPU. The acknowledge register gives the lowest-numbered source that is currently asserting that CPU's IRQ. All reads are combinational and have no side effects.

Top module: `irq_distributor`

## Requirements
- R1: The control register at address 0x000 holds the master enable in bit 0, which reads back as written and is 0 after reset. Bits [11:2] read as the parameter NSRC. All other bits read 0.
- R2: Writing N in wdata[9:0] to 0x030 enables shared source N (32 <= N < NSRC). Writing N to 0x034 disables it. Bits [31:10] of wdata are ignored. Shared sources are disabled after reset.
- R3: A set or clear write whose index is at or above NSRC changes nothing. An enable write (0x030/0x034) that names a private source (N < 32) changes nothing. A control-word write to a source at or above NSRC changes nothing, and that address reads 0.
- R4: The window of CPU c starts at 0x2000 + 0x100*c. Writing N < 32 to offset 0x48 masks private source N for CPU c only. Writing N to offset 0x4C unmasks it for CPU c only. After reset every private source is masked on every CPU.
- R5: The control word of source N is at 0x100 + 4*N. Bit c routes the source to CPU c as an IRQ, and bit 8+c routes it to CPU c as an FIQ. The word reads back these bits, all other bits read 0, and the word is 0 after reset.
- R6: The cause register at CPU offset 0x10 has bit N (N < 32) set when source N is asserted and routed to that CPU as IRQ or FIQ. Masks and the master enable do not affect it.
- R7: The acknowledge register at CPU offset 0x44 returns, in bits [9:0], the lowest N that is asserted, unmasked or enabled, and IRQ-routed to that CPU. If there is no such N it returns 0x3FF. The master enable does not gate it.
- R8: irq_o[c] is high when the master enable is set and at least one source is asserted, unmasked or enabled, and IRQ-routed to CPU c. fiq_o[c] follows the same rule with the FIQ route bits.
- R9: Clearing the master enable drives every irq_o and fiq_o low, and setting it again restores them without any change to the enables, masks or routes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_o | output | NCPU | IRQ line per CPU |
| fiq_o | output | NCPU | FIQ line per CPU |

## Verification
The bench builds the block with NCPU=2 and NSRC=40. Forty sources include all 32 private sources and a short shared range. The count is not a power of two, so indices just past the top (40 and above, up to 1023) can be written as out-of-range values. Every source is swept one at a time, and a four-way rotation of route patterns covers IRQ-only, FIQ-only and mixed routing on both CPUs. Two CPUs are enough to show that a mask write on one CPU leaves the other's copy untouched. Lowest-first acknowledge ordering is checked by retiring sources one by one from a fully pending vector.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NCPU   = 2,
  parameter int NSRC   = 64,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCPU-1:0]   irq_o,
  output logic [NCPU-1:0]   fiq_o
);
  localparam int NPRIV    = 32;
  localparam int NSHR     = NSRC - NPRIV;
  localparam int CTL_BASE = 'h100;
  localparam int CPU_BASE = 'h2000;
  localparam logic [9:0] NONE = 10'h3FF;

  logic             gen_q;
  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  irt_q [NCPU];
  logic [NSRC-1:0]  frt_q [NCPU];
  logic [NPRIV-1:0] msk_q [NCPU];
  logic [NSRC-1:0]  irq_v [NCPU];
  logic [NSRC-1:0]  fiq_v [NCPU];
  logic [9:0]       ack   [NCPU];
  logic [NCPU-1:0]  cpu_hit;
  logic             unused_wdata;

  wire [9:0] idx    = wdata[9:0];
  wire       set_en = wr_en && addr == ADDR_W'('h30);
  wire       clr_en = wr_en && addr == ADDR_W'('h34);
  wire       idx_shr = int'(idx) >= NPRIV && int'(idx) < NSRC;

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gen_q <= 1'b0;
    else if (wr_en && addr == '0) gen_q <= wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if ((set_en || clr_en) && idx_shr)
      for (int n = NPRIV; n < NSRC; n++)
        if (int'(idx) == n) en_q[n] <= set_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        irt_q[c] <= '0;
        frt_q[c] <= '0;
      end
    end else if (wr_en) begin
      for (int n = 0; n < NSRC; n++)
        if (int'(addr) == CTL_BASE + 4*n)
          for (int c = 0; c < NCPU; c++) begin
            irt_q[c][n] <= wdata[c];
            frt_q[c][n] <= wdata[8+c];
          end
    end

  genvar gc;
  generate
    for (gc = 0; gc < NCPU; gc++) begin : g_cpu
      assign cpu_hit[gc] = int'(addr[ADDR_W-1:8]) == (CPU_BASE >> 8) + gc;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) msk_q[gc] <= '1;
        else if (wr_en && cpu_hit[gc] && (addr[7:0] == 8'h48 || addr[7:0] == 8'h4C))
          for (int n = 0; n < NPRIV; n++)
            if (int'(idx) == n) msk_q[gc][n] <= (addr[7:0] == 8'h48);

      wire [NSRC-1:0] gate = {en_q[NSRC-1:NPRIV], ~msk_q[gc]};
      assign irq_v[gc] = src_i & gate & irt_q[gc];
      assign fiq_v[gc] = src_i & gate & frt_q[gc];
      assign irq_o[gc] = gen_q && |irq_v[gc];
      assign fiq_o[gc] = gen_q && |fiq_v[gc];

      always_comb begin
        ack[gc] = NONE;
        for (int n = NSRC - 1; n >= 0; n--)
          if (irq_v[gc][n]) ack[gc] = 10'(n);
      end

      a_r4_mask_private: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cpu_hit[gc]) |=> $stable(msk_q[gc]));
      a_r7_ack_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[gc] == NONE || int'(ack[gc]) < NSRC));
      a_r8_irq_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[gc] |-> ack[gc] != NONE);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      rdata[0]    = gen_q;
      rdata[11:2] = 10'(NSRC);
    end
    for (int n = 0; n < NSRC; n++)
      if (int'(addr) == CTL_BASE + 4*n)
        for (int c = 0; c < NCPU; c++) begin
          rdata[c]   = irt_q[c][n];
          rdata[8+c] = frt_q[c][n];
        end
    for (int c = 0; c < NCPU; c++)
      if (cpu_hit[c]) begin
        if (addr[7:0] == 8'h10)
          rdata = src_i[NPRIV-1:0] & (irt_q[c][NPRIV-1:0] | frt_q[c][NPRIV-1:0]);
        else if (addr[7:0] == 8'h44)
          rdata = {22'b0, ack[c]};
      end
  end

  a_r2_set_top: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && int'(idx) == NSRC - 1) |=> en_q[NSRC-1]);
  a_r2_clr_top: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && int'(idx) == NSRC - 1) |=> !en_q[NSRC-1]);
  a_r3_oob_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_en || clr_en) && !idx_shr) |=> $stable(en_q));

  if (NSHR < 1) begin : g_bad
    initial $error("NSRC must exceed 32");
  end
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
  localparam int CLK_P = 10;
  localparam int NC = 2;
  localparam int NS = 40;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [NS-1:0] src = '0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NC-1:0] irq, fiq;
  int checks = 0, errors = 0;

  logic gen_m;
  logic en_m [NS];
  logic msk_m [NC][32];
  logic irt_m [NC][NS];
  logic frt_m [NC][NS];

  always #(CLK_P/2) clk = ~clk;

  irq_distributor #(.NCPU(NC), .NSRC(NS), .ADDR_W(14)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq), .fiq_o(fiq));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(logic [13:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  function automatic logic elig(int c, int n);
    return src[n] && (n < 32 ? !msk_m[c][n] : en_m[n]);
  endfunction

  task automatic check_state(string req);
    logic [31:0] v, cause, ackv;
    logic ei, ef;
    for (int c = 0; c < NC; c++) begin
      cause = '0; ackv = 32'h3FF; ei = 0; ef = 0;
      for (int n = NS - 1; n >= 0; n--) begin
        if (n < 32) cause[n] = src[n] && (irt_m[c][n] || frt_m[c][n]);
        if (elig(c, n) && irt_m[c][n]) begin ackv = n; ei = 1; end
        if (elig(c, n) && frt_m[c][n]) ef = 1;
      end
      rd(14'h2010 + 14'(c*256), v); chk({req, " R6 cause"}, v, cause);
      rd(14'h2044 + 14'(c*256), v); chk({req, " R7 ack"}, v, ackv);
      chk({req, " R8 irq"}, 32'(irq[c]), 32'(ei && gen_m));
      chk({req, " R8 fiq"}, 32'(fiq[c]), 32'(ef && gen_m));
    end
  endtask

  task automatic set_en(int n, logic [31:0] hi = 0);
    wr(14'h030, hi | 32'(n));
    if (n >= 32 && n < NS) en_m[n] = 1;
  endtask
  task automatic clr_en(int n);
    wr(14'h034, 32'(n));
    if (n >= 32 && n < NS) en_m[n] = 0;
  endtask
  task automatic msk(int c, int n, logic m);
    wr(14'h2000 + 14'(c*256) + (m ? 14'h48 : 14'h4C), 32'(n));
    if (n < 32) msk_m[c][n] = m;
  endtask
  task automatic wctl(int n, logic [31:0] w);
    wr(14'h100 + 14'(4*n), w);
    if (n < NS)
      for (int c = 0; c < NC; c++) begin
        irt_m[c][n] = w[c]; frt_m[c][n] = w[8+c];
      end
  endtask
  task automatic wgen(logic g);
    wr(14'h000, 32'(g)); gen_m = g;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    gen_m = 0;
    for (int n = 0; n < NS; n++) begin
      en_m[n] = 0;
      for (int c = 0; c < NC; c++) begin irt_m[c][n] = 0; frt_m[c][n] = 0; end
    end
    for (int c = 0; c < NC; c++) for (int n = 0; n < 32; n++) msk_m[c][n] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(14'h000, v); chk("R1 reset ctrl", v, NS << 2);
    rd(14'h104, v); chk("R5 reset ctl word", v, 0);
    src = '1; #1; check_state("R4 reset all masked");
    src = '0;
    wgen(1);
    rd(14'h000, v); chk("R1 enable readback", v, (NS << 2) | 1);

    for (int n = 0; n < NS; n++) begin
      case (n % 4)
        0: w = 32'h0000_0001;
        1: w = 32'h0000_0002;
        2: w = 32'h0000_0102;
        default: w = 32'h0000_0203;
      endcase
      wctl(n, w | 32'hFFF0_F0F0);
      rd(14'h100 + 14'(4*n), v); chk("R5 route readback", v, w);
      src = '0; src[n] = 1'b1; #1;
      check_state("R6 routed not enabled");
      if (n < 32) msk(n % 2, n, 0); else set_en(n);
      check_state("R8 enabled single source");
      if (n < 32) msk(n % 2, n, 1); else clr_en(n);
      check_state("R2 R4 disabled again");
    end

    src = '1; #1;
    set_en(33, 32'hFFFF_FC00);
    check_state("R2 upper bits ignored");
    set_en(40); set_en(1023); clr_en(44);
    check_state("R3 out of range enable");
    wctl(3, 32'h0000_0001);
    set_en(3); clr_en(33);
    check_state("R3 private index on enable reg");
    wctl(NS, 32'h0000_0303);
    rd(14'h100 + 14'(4*NS), v); chk("R3 ctl beyond NSRC reads 0", v, 0);
    check_state("R3 ctl beyond NSRC no effect");
    msk(0, 40, 0);
    check_state("R3 mask index above private range");

    wctl(5, 32'h0000_0003);
    msk(0, 5, 0);
    check_state("R4 mask isolation cpu0 only");
    chk("R4 cpu1 still masked irq", 32'(irq[1]), 0);

    for (int n = 0; n < NS; n++) wctl(n, 32'h0000_0303);
    for (int n = 0; n < 32; n++) begin msk(0, n, 0); msk(1, n, 0); end
    for (int n = 32; n < NS; n++) set_en(n);
    for (int n = 0; n < NS; n++) begin
      src[n] = 1'b0; #1;
      check_state("R7 lowest first retire");
    end

    src = 40'h80_0000_1000; #1;
    wgen(0);
    check_state("R9 master off");
    wgen(1);
    check_state("R9 master restored");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule